// File: doc/BRIEF.md
# Control Register Access Unit

This unit holds a bank of 64-bit control registers that a processor core reads and writes by index. Each register has its own write rule: most keep only certain bits of the written value, a few are cleared by any write, some may only be read and some may only be written. A handful of writes are really commands: they store nothing useful and instead emit a one-cycle strobe that tells the data or instruction translation buffer to drop all entries, drop the entries of the current process, or drop one address.

A read is requested with `rd_en` and an index. The result and a fault flag appear one cycle later. An illegal access raises the fault flag, which the core turns into an unimplemented-opcode trap. Writes issued while the core is still speculating (`spec` high) are dropped silently. The cycle-count register is special on reads: the upper half comes from storage and the lower half comes from a free-running counter inside the unit.

Top module: `ipr_access_unit`

## Requirements
- R1: After reset every register reads zero, except the handler base (index 24), which reads the `HANDLER_RST` parameter, and the memory control register (index 28), which reads 0x6. While reset is held, `rdata` and `fault` are 0.
- R2: A read strobe at a clock edge puts the data and the fault flag on `rdata`/`fault` in the next cycle. `rdata` is 0 in every cycle that follows no read, and in every cycle that follows a faulting read. A read and a write issued in the same cycle return the value held before the write.
- R3: Writes keep only a per-register mask. Indices 32 and 33 keep 0xf. Index 34 keeps 0x1f. Indices 35, 36 and 37 keep 0x18. Index 38 keeps 0x7fff0. Index 39 keeps 0xffffff0300. Indices 40 and 41 keep 0xffffffffc0000000. Index 42 keeps 0x1ffb. Indices 43 and 44 keep 0x3f. Index 45 keeps 0x7f0. Index 46 keeps 0xfe00000000000000.
- R4: A write to the exception restart address (index 31) stores the value with bit 1 forced to 0.
- R5: Any write to the exception summary (index 47) or exception mask (index 48) leaves it reading zero.
- R6: Indices 49 to 53 are read-only. A non-speculative write to one of them raises `fault` in the next cycle and changes nothing.
- R7: Indices 37 and 54 to 63 are write-only. Index 30 and every index of 64 or more are unknown. A read of any of these raises `fault` with `rdata` 0. A non-speculative write to an unknown index also raises `fault`.
- R8: A read of the cycle register (index 29) returns the stored bits 63:32 together with a 32-bit count in bits 31:0. The count is 0 at the first clock edge after reset and advances by one at every edge.
- R9: A write to index 58/59/60 pulses `dtlb_inv_all`/`dtlb_inv_proc`/`dtlb_inv_va`, and a write to index 61/62/63 pulses `itlb_inv_all`/`itlb_inv_proc`/`itlb_inv_va`, for one cycle after the write edge. Indices 58, 59, 61 and 62 store zero. For 60 and 63, `inv_addr` carries the written value in the strobe cycle and is 0 otherwise. At most one strobe is high at a time.
- R10: A write with `spec` high changes no register, raises no fault and emits no strobe.
- R11: Scratch indices 0 to 23 and indices 24 to 29 and 54 to 57 store the full 64-bit write value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request for `idx` |
| wr_en | input | 1 | Write request for `idx` |
| spec | input | 1 | Core is speculating; writes are dropped |
| idx | input | 7 | Register index |
| wdata | input | 64 | Write value |
| rdata | output | 64 | Read result, one cycle after `rd_en` |
| fault | output | 1 | Illegal access, one cycle after the request |
| dtlb_inv_all | output | 1 | Data translation buffer: drop all entries |
| dtlb_inv_proc | output | 1 | Data translation buffer: drop per-process entries |
| dtlb_inv_va | output | 1 | Data translation buffer: drop one address |
| itlb_inv_all | output | 1 | Instruction translation buffer: drop all entries |
| itlb_inv_proc | output | 1 | Instruction translation buffer: drop per-process entries |
| itlb_inv_va | output | 1 | Instruction translation buffer: drop one address |
| inv_addr | output | 64 | Address for the single-address invalidate |

## Verification
A read and a write can land in the same cycle, and they can hit different rules. Examples are a read of a scratch register while that same register is written, and a read of a write-only invalidate register while it is written, which gives a read fault and an invalidate strobe together. The bench issues both strobes together on purpose. Its reference model evaluates the read against the register state from before the edge and applies the write afterwards. The next cycle's data, fault and strobes are then compared against that model.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned IDX_W     = 7;
    localparam int unsigned CNT_W     = 32;
    localparam int unsigned SLOTS     = 64;
    localparam int unsigned SLOT_W    = $clog2(SLOTS);
    localparam int unsigned SCR_COUNT = 24;
    localparam int unsigned N_INV     = 6;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // register index map
    localparam idx_t IDX_HBASE    = idx_t'(24);
    localparam idx_t IDX_IPERR    = idx_t'(25);
    localparam idx_t IDX_DPERR    = idx_t'(26);
    localparam idx_t IDX_PERF     = idx_t'(27);
    localparam idx_t IDX_MEMCTL   = idx_t'(28);
    localparam idx_t IDX_CYCLE    = idx_t'(29);
    localparam idx_t IDX_EXCADDR  = idx_t'(31);
    localparam idx_t IDX_ASTREQ   = idx_t'(32);
    localparam idx_t IDX_ASTEN    = idx_t'(33);
    localparam idx_t IDX_IRQLVL   = idx_t'(34);
    localparam idx_t IDX_IMODE    = idx_t'(35);
    localparam idx_t IDX_DMODE    = idx_t'(36);
    localparam idx_t IDX_ALTMODE  = idx_t'(37);
    localparam idx_t IDX_SOFTREQ  = idx_t'(38);
    localparam idx_t IDX_ISTAT    = idx_t'(39);
    localparam idx_t IDX_IPTB     = idx_t'(40);
    localparam idx_t IDX_DPTB     = idx_t'(41);
    localparam idx_t IDX_DCTEST   = idx_t'(42);
    localparam idx_t IDX_DCMODE   = idx_t'(43);
    localparam idx_t IDX_MAFMODE  = idx_t'(44);
    localparam idx_t IDX_IASN     = idx_t'(45);
    localparam idx_t IDX_DASN     = idx_t'(46);
    localparam idx_t IDX_EXCSUM   = idx_t'(47);
    localparam idx_t IDX_EXCMASK  = idx_t'(48);
    localparam idx_t IDX_INTID    = idx_t'(49);
    localparam idx_t IDX_SERRX    = idx_t'(50);
    localparam idx_t IDX_MEMSTAT  = idx_t'(51);
    localparam idx_t IDX_IPTETMP  = idx_t'(52);
    localparam idx_t IDX_DPTETMP  = idx_t'(53);
    localparam idx_t IDX_INTCLR   = idx_t'(54);
    localparam idx_t IDX_SERTX    = idx_t'(55);
    localparam idx_t IDX_DFLUSH   = idx_t'(56);
    localparam idx_t IDX_IFLUSH   = idx_t'(57);
    localparam idx_t IDX_DINVALL  = idx_t'(58);
    localparam idx_t IDX_DINVPROC = idx_t'(59);
    localparam idx_t IDX_DINVONE  = idx_t'(60);
    localparam idx_t IDX_IINVALL  = idx_t'(61);
    localparam idx_t IDX_IINVPROC = idx_t'(62);
    localparam idx_t IDX_IINVONE  = idx_t'(63);

    // write masks
    localparam word_t KEEP_ALL     = '1;
    localparam word_t KEEP_NONE    = '0;
    localparam word_t KEEP_EXCADDR = ~word_t'(64'h2);
    localparam word_t KEEP_AST     = word_t'(64'hf);
    localparam word_t KEEP_LEVEL   = word_t'(64'h1f);
    localparam word_t KEEP_MODE    = word_t'(64'h18);
    localparam word_t KEEP_SOFT    = word_t'(64'h7fff0);
    localparam word_t KEEP_ISTAT   = word_t'(64'hff_ffff_0300);
    localparam word_t KEEP_PTB     = word_t'(64'hffff_ffff_c000_0000);
    localparam word_t KEEP_DCTEST  = word_t'(64'h1ffb);
    localparam word_t KEEP_CMODE   = word_t'(64'h3f);
    localparam word_t KEEP_IASN    = word_t'(64'h7f0);
    localparam word_t KEEP_DASN    = word_t'(64'hfe00_0000_0000_0000);

    typedef enum logic [2:0] {
        INV_NONE    = 3'd0,
        INV_D_ALL   = 3'd1,
        INV_D_PROC  = 3'd2,
        INV_D_ONE   = 3'd3,
        INV_I_ALL   = 3'd4,
        INV_I_PROC  = 3'd5,
        INV_I_ONE   = 3'd6
    } inv_e;

    typedef struct packed {
        logic  rd_ok;
        logic  wr_ok;
        logic  cyc_rd;
        inv_e  inv;
        word_t keep;
    } acc_t;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] bank;
        word_t                        rdata;
        logic                         fault;
        logic [N_INV-1:0]             strobe;
        word_t                        inv_addr;
    } state_t;
endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output acc_t             acc
);
    localparam idx_t SCR_LIMIT = idx_t'(SCR_COUNT);

    always_comb begin
        acc = '0;
        if (idx < SCR_LIMIT) begin
            acc.rd_ok = 1'b1;
            acc.wr_ok = 1'b1;
            acc.keep  = KEEP_ALL;
        end else begin
            case (idx)
                IDX_HBASE, IDX_IPERR, IDX_DPERR, IDX_PERF, IDX_MEMCTL: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_ALL;
                end
                IDX_CYCLE: begin
                    acc.rd_ok  = 1'b1;
                    acc.wr_ok  = 1'b1;
                    acc.cyc_rd = 1'b1;
                    acc.keep   = KEEP_ALL;
                end
                IDX_EXCADDR: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_EXCADDR;
                end
                IDX_ASTREQ, IDX_ASTEN: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_AST;
                end
                IDX_IRQLVL: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_LEVEL;
                end
                IDX_IMODE, IDX_DMODE: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_MODE;
                end
                IDX_ALTMODE: begin
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_MODE;
                end
                IDX_SOFTREQ: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_SOFT;
                end
                IDX_ISTAT: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_ISTAT;
                end
                IDX_IPTB, IDX_DPTB: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_PTB;
                end
                IDX_DCTEST: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_DCTEST;
                end
                IDX_DCMODE, IDX_MAFMODE: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_CMODE;
                end
                IDX_IASN: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_IASN;
                end
                IDX_DASN: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_DASN;
                end
                IDX_EXCSUM, IDX_EXCMASK: begin
                    acc.rd_ok = 1'b1;
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_NONE;
                end
                IDX_INTID, IDX_SERRX, IDX_MEMSTAT, IDX_IPTETMP, IDX_DPTETMP: begin
                    acc.rd_ok = 1'b1;
                end
                IDX_INTCLR, IDX_SERTX, IDX_DFLUSH, IDX_IFLUSH: begin
                    acc.wr_ok = 1'b1;
                    acc.keep  = KEEP_ALL;
                end
                IDX_DINVALL: begin
                    acc.wr_ok = 1'b1;
                    acc.inv   = INV_D_ALL;
                end
                IDX_DINVPROC: begin
                    acc.wr_ok = 1'b1;
                    acc.inv   = INV_D_PROC;
                end
                IDX_DINVONE: begin
                    acc.wr_ok = 1'b1;
                    acc.inv   = INV_D_ONE;
                    acc.keep  = KEEP_ALL;
                end
                IDX_IINVALL: begin
                    acc.wr_ok = 1'b1;
                    acc.inv   = INV_I_ALL;
                end
                IDX_IINVPROC: begin
                    acc.wr_ok = 1'b1;
                    acc.inv   = INV_I_PROC;
                end
                IDX_IINVONE: begin
                    acc.wr_ok = 1'b1;
                    acc.inv   = INV_I_ONE;
                    acc.keep  = KEEP_ALL;
                end
                default: acc = '0;
            endcase
        end
    end
endmodule

// File: rtl/ipr_cycle_counter.sv
module ipr_cycle_counter #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_ni,
    output logic [WIDTH-1:0] count
);
    logic [WIDTH-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/ipr_strobe_decode.sv
module ipr_strobe_decode
    import ipr_pkg::*;
(
    input  inv_e             kind,
    input  logic             fire,
    output logic [N_INV-1:0] strobe
);
    // bit g answers to invalidate kind g+1
    for (genvar g = 0; g < N_INV; g++) begin : g_strobe
        assign strobe[g] = fire && (kind == inv_e'(3'(g + 1)));
    end
endmodule

// File: rtl/ipr_access_unit.sv
module ipr_access_unit
    import ipr_pkg::*;
#(
    parameter logic [63:0] HANDLER_RST = 64'h0000_0000_0001_0000,
    parameter logic [63:0] MEMCTL_RST  = 64'h0000_0000_0000_0006
) (
    input  logic                clk,
    input  logic                rst_ni,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic                spec,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                fault,
    output logic                dtlb_inv_all,
    output logic                dtlb_inv_proc,
    output logic                dtlb_inv_va,
    output logic                itlb_inv_all,
    output logic                itlb_inv_proc,
    output logic                itlb_inv_va,
    output logic [DATA_W-1:0]   inv_addr
);
    localparam int unsigned HBASE_SLOT  = int'(IDX_HBASE);
    localparam int unsigned MEMCTL_SLOT = int'(IDX_MEMCTL);

    state_t             state_d, state_q;
    acc_t               acc;
    logic [CNT_W-1:0]   cycles;
    logic [SLOT_W-1:0]  slot;
    logic               commit;
    logic [N_INV-1:0]   strobe_d;

    assign slot   = idx[SLOT_W-1:0];
    assign commit = wr_en && !spec && acc.wr_ok;

    ipr_decode u_decode (
        .idx (idx),
        .acc (acc)
    );

    ipr_cycle_counter #(
        .WIDTH (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_ni (rst_ni),
        .count  (cycles)
    );

    ipr_strobe_decode u_strobe (
        .kind   (acc.inv),
        .fire   (commit),
        .strobe (strobe_d)
    );

    always_comb begin
        state_d          = state_q;
        state_d.rdata    = '0;
        state_d.fault    = 1'b0;
        state_d.inv_addr = '0;
        state_d.strobe   = strobe_d;

        // read sees the contents from before this edge
        if (rd_en) begin
            if (acc.rd_ok) begin
                if (acc.cyc_rd) begin
                    state_d.rdata = {state_q.bank[slot][DATA_W-1:CNT_W], cycles};
                end else begin
                    state_d.rdata = state_q.bank[slot];
                end
            end else begin
                state_d.fault = 1'b1;
            end
        end

        if (wr_en && !spec) begin
            if (acc.wr_ok) begin
                state_d.bank[slot] = wdata & acc.keep;
                if (acc.inv == INV_D_ONE || acc.inv == INV_I_ONE) begin
                    state_d.inv_addr = wdata;
                end
            end else begin
                state_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q                   <= '0;
            state_q.bank[HBASE_SLOT]  <= HANDLER_RST;
            state_q.bank[MEMCTL_SLOT] <= MEMCTL_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata         = state_q.rdata;
    assign fault         = state_q.fault;
    assign inv_addr      = state_q.inv_addr;
    assign dtlb_inv_all  = state_q.strobe[0];
    assign dtlb_inv_proc = state_q.strobe[1];
    assign dtlb_inv_va   = state_q.strobe[2];
    assign itlb_inv_all  = state_q.strobe[3];
    assign itlb_inv_proc = state_q.strobe[4];
    assign itlb_inv_va   = state_q.strobe[5];
endmodule

// File: rtl/ipr_access_checker.sv
module ipr_access_checker
    import ipr_pkg::*;
(
    input logic              clk,
    input logic              rst_ni,
    input logic              rd_en,
    input logic              wr_en,
    input logic              spec,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] rdata,
    input logic              fault,
    input logic              dtlb_inv_all,
    input logic              dtlb_inv_proc,
    input logic              dtlb_inv_va,
    input logic              itlb_inv_all,
    input logic              itlb_inv_proc,
    input logic              itlb_inv_va
);
    logic [N_INV-1:0] strobes;
    assign strobes = {itlb_inv_va, itlb_inv_proc, itlb_inv_all,
                      dtlb_inv_va, dtlb_inv_proc, dtlb_inv_all};

    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        !rd_en |=> (rdata == '0));

    assert_level_mask_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_en && idx == IDX_IRQLVL) |=> (rdata[DATA_W-1:5] == '0));

    assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && !spec && idx == IDX_EXCSUM) ##1 (rd_en && !wr_en && idx == IDX_EXCSUM)
        |=> (rdata == '0));

    assert_readonly_write_faults_R6: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && !spec && idx == IDX_INTID) |=> fault);

    assert_unknown_read_faults_R7: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_en && idx[IDX_W-1:SLOT_W] != '0) |=> (fault && rdata == '0));

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        $onehot0(strobes));

    assert_no_write_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        !wr_en |=> (strobes == '0));

    assert_spec_write_silent_R10: assert property (@(posedge clk) disable iff (!rst_ni)
        (wr_en && spec && !rd_en) |=> (!fault && strobes == '0));
endmodule

bind ipr_access_unit ipr_access_checker u_checker (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .spec          (spec),
    .idx           (idx),
    .rdata         (rdata),
    .fault         (fault),
    .dtlb_inv_all  (dtlb_inv_all),
    .dtlb_inv_proc (dtlb_inv_proc),
    .dtlb_inv_va   (dtlb_inv_va),
    .itlb_inv_all  (itlb_inv_all),
    .itlb_inv_proc (itlb_inv_proc),
    .itlb_inv_va   (itlb_inv_va)
);

// File: tb/ipr_access_unit_bench.sv
module ipr_access_unit_bench;
    localparam logic [63:0] HRST = 64'h0000_0000_0001_0000;
    localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, spec = 1'b0;
    logic [6:0]  idx = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata, inv_addr;
    logic        fault;
    logic        dtlb_inv_all, dtlb_inv_proc, dtlb_inv_va;
    logic        itlb_inv_all, itlb_inv_proc, itlb_inv_va;

    always #10 clk = ~clk;   // 50 MHz

    ipr_access_unit #(.HANDLER_RST(HRST)) u_ipr_access_unit (
        .clk(clk), .rst_ni(rst_ni), .rd_en(rd_en), .wr_en(wr_en), .spec(spec),
        .idx(idx), .wdata(wdata), .rdata(rdata), .fault(fault),
        .dtlb_inv_all(dtlb_inv_all), .dtlb_inv_proc(dtlb_inv_proc), .dtlb_inv_va(dtlb_inv_va),
        .itlb_inv_all(itlb_inv_all), .itlb_inv_proc(itlb_inv_proc), .itlb_inv_va(itlb_inv_va),
        .inv_addr(inv_addr)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycle_n = 0;
    bit    active = 1'b0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    // reference model state
    logic [63:0] m_bank [64];
    logic [31:0] m_cnt;
    logic [63:0] e_rdata, e_addr;
    logic        e_fault;
    logic [5:0]  e_strb;

    function automatic logic [63:0] keep_of(int i);
        if (i <= 29) return ONES;
        case (i)
            31: return ~64'h2;
            32, 33: return 64'hf;
            34: return 64'h1f;
            35, 36, 37: return 64'h18;
            38: return 64'h7fff0;
            39: return 64'hff_ffff_0300;
            40, 41: return 64'hffff_ffff_c000_0000;
            42: return 64'h1ffb;
            43, 44: return 64'h3f;
            45: return 64'h7f0;
            46: return 64'hfe00_0000_0000_0000;
            54, 55, 56, 57, 60, 63: return ONES;
            default: return 64'h0;
        endcase
    endfunction

    function automatic bit can_read(int i);
        return (i <= 29) || (i >= 31 && i <= 36) || (i >= 38 && i <= 53);
    endfunction

    function automatic bit can_write(int i);
        return (i <= 29) || (i >= 31 && i <= 48) || (i >= 54 && i <= 63);
    endfunction

    always @(posedge clk) begin
        if (!rst_ni) begin
            for (int i = 0; i < 64; i++) m_bank[i] = 64'h0;
            m_bank[24] = HRST;
            m_bank[28] = 64'h6;
            m_cnt   = 32'h0;
            e_rdata = '0; e_fault = 1'b0; e_strb = '0; e_addr = '0;
        end else begin
            int i;
            i = int'(idx);
            e_rdata = '0; e_fault = 1'b0; e_strb = '0; e_addr = '0;
            exp_tag = cur_tag;
            if (rd_en) begin
                if (can_read(i)) e_rdata = (i == 29) ? {m_bank[29][63:32], m_cnt} : m_bank[i];
                else e_fault = 1'b1;
            end
            if (wr_en && !spec) begin
                if (can_write(i)) begin
                    m_bank[i] = wdata & keep_of(i);
                    if (i >= 58) e_strb[i-58] = 1'b1;
                    if (i == 60 || i == 63) e_addr = wdata;
                end else begin
                    e_fault = 1'b1;
                end
            end
            m_cnt = m_cnt + 32'd1;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (active) begin
            logic [5:0] strb;
            strb = {itlb_inv_va, itlb_inv_proc, itlb_inv_all, dtlb_inv_va, dtlb_inv_proc, dtlb_inv_all};
            checks += 3;
            if (rdata !== e_rdata) begin
                errors++;
                $display("FAIL %s rdata: actual %h expected %h", exp_tag, rdata, e_rdata);
            end
            if (fault !== e_fault) begin
                errors++;
                $display("FAIL %s fault: actual %b expected %b", exp_tag, fault, e_fault);
            end
            if (strb !== e_strb || inv_addr !== e_addr) begin
                errors++;
                $display("FAIL %s strobes/addr: actual %b/%h expected %b/%h",
                         exp_tag, strb, inv_addr, e_strb, e_addr);
            end
        end
    end

    always @(posedge clk) begin
        cycle_n++;
        if (cycle_n == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycle_n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic op(input string tag, input bit r, input bit w, input bit s,
                      input int i, input logic [63:0] d);
        @(negedge clk);
        cur_tag = tag;
        rd_en = r; wr_en = w; spec = s;
        idx = 7'(i); wdata = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks += 2;
        if (rdata !== 64'h0 || fault !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: actual %h/%b expected 0/0", rdata, fault);
        end
        rst_ni = 1'b1;
        active = 1'b1;

        // R1 reset contents
        op("R1", 1, 0, 0, 24, 0);
        op("R1", 1, 0, 0, 28, 0);
        op("R1", 1, 0, 0, 5, 0);
        op("R1", 1, 0, 0, 34, 0);
        op("R2", 0, 0, 0, 24, 0);

        // R11 full-width registers
        for (int i = 0; i < 24; i++) op("R11", 0, 1, 0, i, {32'hdead_0000 + 32'(i), 32'h1234_5678});
        for (int i = 0; i < 24; i++) op("R11", 1, 0, 0, i, 0);
        for (int i = 24; i <= 29; i++) op("R11", 0, 1, 0, i, 64'h0f0f_1234_aaaa_5555 ^ 64'(i));
        for (int i = 24; i <= 28; i++) op("R11", 1, 0, 0, i, 0);

        // R3 masks with two patterns
        for (int i = 32; i <= 46; i++) begin
            op("R3", 0, 1, 0, i, ONES);
            op("R3", 1, 0, 0, i, 0);
            op("R3", 1, 1, 0, i, 64'h5a5a_a5a5_3c3c_c3c3);
            op("R3", 1, 0, 0, i, 0);
        end

        // R4 exception restart address
        op("R4", 0, 1, 0, 31, ONES);
        op("R4", 1, 0, 0, 31, 0);
        op("R4", 0, 1, 0, 31, 64'h0000_1000_0000_0006);
        op("R4", 1, 0, 0, 31, 0);

        // R5 clear on write
        op("R5", 0, 1, 0, 47, ONES);
        op("R5", 1, 0, 0, 47, 0);
        op("R5", 0, 1, 0, 48, 64'h77);
        op("R5", 1, 0, 0, 48, 0);

        // R6 read-only
        for (int i = 49; i <= 53; i++) begin
            op("R6", 0, 1, 0, i, ONES);
            op("R6", 1, 0, 0, i, 0);
        end

        // R7 write-only and unknown
        op("R7", 1, 0, 0, 37, 0);
        for (int i = 54; i <= 63; i++) op("R7", 1, 0, 0, i, 0);
        op("R7", 1, 0, 0, 30, 0);
        op("R7", 0, 1, 0, 30, ONES);
        op("R7", 1, 0, 0, 100, 0);
        op("R7", 0, 1, 0, 127, ONES);
        op("R7", 0, 1, 0, 56, ONES);

        // R8 cycle register splice
        op("R8", 0, 1, 0, 29, 64'haaaa_bbbb_cccc_dddd);
        op("R8", 1, 0, 0, 29, 0);
        op("R8", 1, 0, 0, 29, 0);
        op("R8", 0, 0, 0, 0, 0);
        op("R8", 1, 0, 0, 29, 0);

        // R9 invalidate strobes
        for (int i = 58; i <= 63; i++) begin
            op("R9", 0, 1, 0, i, 64'h0000_7fff_0000_2000 + 64'(i));
            op("R9", 0, 0, 0, 0, 0);
        end
        op("R9", 0, 1, 0, 60, 64'h1111_2222_3333_4444);
        op("R9", 0, 1, 0, 63, 64'h5555_6666_7777_8888);

        // R10 speculative writes
        op("R10", 0, 1, 1, 5, 64'hbad0_bad0_bad0_bad0);
        op("R10", 1, 0, 0, 5, 0);
        op("R10", 0, 1, 1, 49, ONES);
        op("R10", 0, 1, 1, 58, ONES);
        op("R10", 0, 1, 1, 30, ONES);
        op("R10", 1, 1, 1, 34, ONES);

        // R2 read and write in the same cycle
        op("R2", 0, 1, 0, 7, 64'h0102_0304_0506_0708);
        op("R2", 1, 1, 0, 7, 64'h1112_1314_1516_1718);
        op("R2", 1, 0, 0, 7, 0);
        op("R2", 1, 1, 0, 58, ONES);
        op("R2", 1, 1, 0, 49, ONES);
        op("R2", 1, 1, 0, 29, 64'h9999_0000_0000_0000);
        op("R2", 0, 0, 0, 0, 0);
        op("R2", 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule